// File: doc/BRIEF.md
# SPI Master Clock-Rate Divider

This block turns the bus clock into the half-period timing of an SPI master's serial clock. A byte-wide rate register holds two fields: a 3-bit multiplier field and a 3-bit power-of-two exponent field. Together they give a bus-clock divisor of (P+1)·2^(S+1). That allows ratios such as 6, 10 or 14, which a single power-of-two setting cannot reach. The block emits a one-cycle `half_tick` each time half an SCK period has elapsed. The shift engine uses these ticks to toggle SCK and to move data.

The counter runs only while the peripheral is master and a transfer is in progress. At all other times it is held cleared, so every new transfer starts with a full, exact first half period. If software writes a new multiplier or exponent while a master transfer is running, the transfer is aborted. The block flags this with a one-cycle `xfer_abort` pulse, and the count restarts from zero under the new setting. A status output reports when the current setting is divide-by-2 while the peripheral is a slave, because that rate is not usable for a received clock.

Top module: `spi_rate_div`

## Requirements
- R1: With multiplier P in bits 6:4 and exponent S in bits 2:0 of the rate register, and the counter running, `half_tick` pulses once every (P+1)·2^S bus clocks. This equals half the divisor (P+1)·2^(S+1), for all 64 settings, from 2 up to 2048.
- R2: After reset the rate register reads 0x00, giving divide-by-2, and `half_tick` and `xfer_abort` are low.
- R3: Bits 7 and 3 of a write are discarded, always read back as zero, and have no effect on the tick spacing.
- R4: No `half_tick` occurs unless `is_master` and `xfer_active` are both high. A tick stops the cycle after either one drops.
- R5: A transfer start resets the count. The first tick comes exactly (P+1)·2^S clocks after the first clock edge that sees the transfer active, even if an earlier transfer stopped part-way through a half period.
- R6: A write that changes P or S while master and active produces `xfer_abort` high for exactly the cycle after the write edge, with no tick in that cycle. The count then restarts from zero with the new setting.
- R7: A write during a master transfer that leaves P and S unchanged, whatever it puts in bits 7 and 3, raises no abort and does not disturb the tick spacing.
- R8: A write that changes P or S while not master, or while no transfer is active, raises no abort.
- R9: `slave_rate_bad` is high exactly when P=0, S=0 and `is_master` is low.
- R10: `rate_rdata` returns the last written P and S in their bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| is_master | input | 1 | Peripheral is configured as master |
| xfer_active | input | 1 | A transfer is in progress |
| rate_wr_en | input | 1 | Write strobe for the rate register |
| rate_wr_data | input | 8 | Write data: P in bits 6:4, S in bits 2:0 |
| rate_rdata | output | 8 | Rate register read value, bits 7 and 3 zero |
| half_tick | output | 1 | One-cycle pulse per SCK half period |
| xfer_abort | output | 1 | One-cycle pulse: rate changed during a master transfer |
| slave_rate_bad | output | 1 | Divide-by-2 selected while the peripheral is a slave |

## Verification
The assertions assume that `is_master`, `xfer_active` and the write port are synchronous to `clk` and change only between edges. They also assume that a rate change during a transfer is a single write strobe, not a level held across many edges. The bench drives every input on the falling edge and pulses `rate_wr_en` for one cycle. It sweeps all 64 field settings with the transfer started only after the write has settled. It then exercises mid-transfer writes, changed and unchanged, at known cycle offsets, so the expected tick and abort cycles follow directly from the divisor arithmetic.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  // Rate register layout; the shift engine and software depend on these positions
  localparam int unsigned RATE_W  = 8;
  localparam int unsigned PRE_W   = 3;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned PRE_LSB = 4;
  localparam int unsigned SEL_LSB = 0;
  // Largest half period is 2^PRE_W * 2^(2^SEL_W - 1); one extra bit holds it
  localparam int unsigned CNT_W   = PRE_W + (1 << SEL_W);

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SEL_W-1:0] sel;
  } rate_fields_t;
endpackage

// File: rtl/spi_rate_reg.sv
module spi_rate_reg
  import spi_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RATE_W-1:0] wr_data,
  input  logic              is_master,
  input  logic              xfer_active,
  output rate_fields_t      fields_o,
  output logic [RATE_W-1:0] rdata_o,
  output logic              restart_o,
  output logic              abort_o
);
  rate_fields_t fields_q, fields_d, wr_fields;
  logic         abort_q, abort_d, changed;

  assign wr_fields.pre = wr_data[PRE_LSB +: PRE_W];
  assign wr_fields.sel = wr_data[SEL_LSB +: SEL_W];

  always_comb begin
    changed   = wr_en && (wr_fields != fields_q);
    restart_o = changed && is_master && xfer_active;
    abort_d   = restart_o;
    fields_d  = fields_q;
    if (wr_en) fields_d = wr_fields;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
      abort_q  <= 1'b0;
    end else begin
      fields_q <= fields_d;
      abort_q  <= abort_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[PRE_LSB +: PRE_W] = fields_q.pre;
    rdata_o[SEL_LSB +: SEL_W] = fields_q.sel;
  end

  assign fields_o = fields_q;
  assign abort_o  = abort_q;

  // R10
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rdata_o));
  // R6
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(is_master && xfer_active && wr_en));
endmodule

// File: rtl/spi_rate_decode.sv
module spi_rate_decode
  import spi_rate_pkg::*;
(
  input  rate_fields_t     fields_i,
  input  logic             is_master,
  output logic [CNT_W-1:0] half_len_o,
  output logic             slave_bad_o
);
  logic [CNT_W-1:0] mult;

  always_comb begin
    mult        = CNT_W'(fields_i.pre) + CNT_W'(1);
    half_len_o  = mult << fields_i.sel;
    slave_bad_o = !is_master && (fields_i.pre == '0) && (fields_i.sel == '0);
  end
endmodule

// File: rtl/spi_half_cnt.sv
module spi_half_cnt #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] half_len_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic [CNT_W-1:0] last_val;

  assign last_val = half_len_i - CNT_W'(1);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!run_i || restart_i) begin
      cnt_d = '0;
    end else if (cnt_q == last_val) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_len_i);
  // R5
  tick_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (cnt_q == '0));
  // R4
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !tick_q);
endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div
  import spi_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              xfer_active,
  input  logic              rate_wr_en,
  input  logic [RATE_W-1:0] rate_wr_data,
  output logic [RATE_W-1:0] rate_rdata,
  output logic              half_tick,
  output logic              xfer_abort,
  output logic              slave_rate_bad
);
  rate_fields_t     fields;
  logic [CNT_W-1:0] half_len;
  logic             restart;
  logic             run;

  assign run = is_master && xfer_active;

  spi_rate_reg reg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (rate_wr_en),
    .wr_data     (rate_wr_data),
    .is_master   (is_master),
    .xfer_active (xfer_active),
    .fields_o    (fields),
    .rdata_o     (rate_rdata),
    .restart_o   (restart),
    .abort_o     (xfer_abort)
  );

  spi_rate_decode dec_i (
    .fields_i    (fields),
    .is_master   (is_master),
    .half_len_o  (half_len),
    .slave_bad_o (slave_rate_bad)
  );

  spi_half_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .restart_i  (restart),
    .half_len_i (half_len),
    .tick_o     (half_tick)
  );

  // R6
  abort_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> !half_tick);
endmodule

// File: tb/spi_rate_div_tb.sv
`timescale 1ns/1ps
module spi_rate_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       is_master = 1'b0;
  logic       xfer_active = 1'b0;
  logic       rate_wr_en = 1'b0;
  logic [7:0] rate_wr_data = 8'h00;
  logic [7:0] rate_rdata;
  logic       half_tick, xfer_abort, slave_rate_bad;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spi_rate_div dut_i (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .xfer_active(xfer_active),
    .rate_wr_en(rate_wr_en), .rate_wr_data(rate_wr_data), .rate_rdata(rate_rdata),
    .half_tick(half_tick), .xfer_abort(xfer_abort), .slave_rate_bad(slave_rate_bad)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_rate(input logic [7:0] v);
    @(negedge clk);
    rate_wr_data = v;
    rate_wr_en   = 1'b1;
    @(negedge clk);
    rate_wr_en   = 1'b0;
  endtask

  // Starts a transfer at a falling edge and counts tick mismatches over n cycles
  task automatic run_ticks(input int half, input int n, output int bad);
    bad = 0;
    xfer_active = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (half_tick != ((i % half) == 0)) bad++;
    end
    xfer_active = 1'b0;
    @(negedge clk);
    if (half_tick) bad++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bad;
    int ticks;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(rate_rdata == 8'h00, "R2 rdata", rate_rdata, 0);
    chk(!half_tick && !xfer_abort, "R2 outputs idle", {half_tick, xfer_abort}, 0);
    // R9 reset setting is divide-by-2 in slave mode
    chk(slave_rate_bad == 1'b1, "R9 slave div2", slave_rate_bad, 1);

    // R4: slave with transfer active gives no ticks
    xfer_active = 1'b1;
    ticks = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (half_tick) ticks++; end
    xfer_active = 1'b0;
    chk(ticks == 0, "R4 slave no tick", ticks, 0);
    is_master = 1'b1;
    @(negedge clk);
    chk(slave_rate_bad == 1'b0, "R9 master clears", slave_rate_bad, 0);
    ticks = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (half_tick) ticks++; end
    chk(ticks == 0, "R4 master idle no tick", ticks, 0);

    // R1 / R10 sweep over all settings
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 8; s++) begin
        write_rate(8'((p << 4) | s));
        chk(rate_rdata == 8'((p << 4) | s), "R10 readback", rate_rdata, (p << 4) | s);
        run_ticks((p + 1) << s, 3 * ((p + 1) << s), bad);
        chk(bad == 0, $sformatf("R1 spacing P=%0d S=%0d", p, s), bad, 0);
      end
    end

    // R3 reserved bits
    write_rate(8'hFF);
    chk(rate_rdata == 8'h77, "R3 reserved read zero", rate_rdata, 8'h77);
    write_rate(8'h88);
    chk(rate_rdata == 8'h00, "R3 reserved only", rate_rdata, 0);
    run_ticks(1, 5, bad);
    chk(bad == 0, "R3 spacing unaffected", bad, 0);

    // R5: partial transfer then restart, half = 4 (P=0,S=2)
    write_rate(8'h02);
    xfer_active = 1'b1;
    repeat (3) @(negedge clk);
    xfer_active = 1'b0;
    @(negedge clk);
    run_ticks(4, 8, bad);
    chk(bad == 0, "R5 exact first half period", bad, 0);

    // R6: change during transfer, half 4 -> 2 (P=1,S=0)
    xfer_active = 1'b1;
    repeat (2) @(negedge clk);
    rate_wr_data = 8'h10;
    rate_wr_en   = 1'b1;
    @(negedge clk);
    rate_wr_en   = 1'b0;
    chk(xfer_abort == 1'b1, "R6 abort pulse", xfer_abort, 1);
    chk(half_tick == 1'b0, "R6 no tick on abort", half_tick, 0);
    @(negedge clk);
    chk(xfer_abort == 1'b0 && half_tick == 1'b0, "R6 abort one cycle", {xfer_abort, half_tick}, 0);
    @(negedge clk);
    chk(half_tick == 1'b1, "R6 restart with new rate", half_tick, 1);
    xfer_active = 1'b0;
    @(negedge clk);

    // R7: same fields, reserved differing, during transfer (half 2)
    xfer_active = 1'b1;
    @(negedge clk);
    rate_wr_data = 8'h98;
    rate_wr_en   = 1'b1;
    @(negedge clk);
    rate_wr_en   = 1'b0;
    chk(xfer_abort == 1'b0, "R7 no abort", xfer_abort, 0);
    chk(half_tick == 1'b1, "R7 spacing kept", half_tick, 1);
    xfer_active = 1'b0;
    @(negedge clk);

    // R8: change while not active, and while slave-active
    write_rate(8'h23);
    chk(xfer_abort == 1'b0, "R8 idle write no abort", xfer_abort, 0);
    is_master   = 1'b0;
    xfer_active = 1'b1;
    @(negedge clk);
    rate_wr_data = 8'h00;
    rate_wr_en   = 1'b1;
    @(negedge clk);
    rate_wr_en   = 1'b0;
    chk(xfer_abort == 1'b0, "R8 slave write no abort", xfer_abort, 0);
    chk(slave_rate_bad == 1'b1, "R9 slave div2 again", slave_rate_bad, 1);
    xfer_active = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule